// File: doc/BRIEF.md
# OSD Character Address Generator

This block walks a page of on-screen-display character codes and turns each into a font ROM address. Each code is 8 bits wide and the page holds up to 512 of them. Once a start strobe arrives, the block issues one page read for each next-character strobe it accepts. It then classifies the returned code. Most codes become a 9-bit font address. The two top bits of the code pick one of four 3-bit bank registers, and that register forms the upper part of the address. Two code values are control marks. They end the current character row or end the whole window, and neither one causes a font fetch.

The font ROM is split into eight banks of 64 glyphs. In each half of the ROM, the last bank holds four-color glyphs, so the block flags a four-color glyph whenever the bank number's two low bits are both set. Software can show a different image from the same page contents by rewriting the bank registers. The timing logic that drives the pixel shifter uses the row-done and window-done pulses.

Top module: `osd_char_addr_gen`

## Requirements
- R1: Synchronous reset leaves the block idle. While idle, no page read is issued and font_vld, row_done and win_done stay low. Reset loads bank register i with the value i.
- R2: While running with no read outstanding, a high next_chr (with start low) raises ram_re for one cycle. ram_addr then carries the read pointer. The pointer is 0 after start and advances by one for each read.
- R3: One cycle after a read, a code of 0x02 or higher raises font_vld. font_addr is then {bank register selected by code[7:6], code[5:0]}, with the bank number in bits [8:6].
- R4: four_color is high exactly when font_vld is high and bits [1:0] of the selected bank number are 11b.
- R5: The response to code 0x01 is a one-cycle row_done with no font_vld. The pointer keeps advancing, and later strobes continue the fetch.
- R6: The response to code 0x00 is a one-cycle win_done with no font_vld. After it, next_chr issues no read until start is pulsed again.
- R7: Only the full code values 0x00 and 0x01 are control marks. Codes 0x40, 0x41, 0x80, 0x81, 0xC0 and 0xC1 fetch fonts even when their bank register holds the same value as register 0.
- R8: The response to a read of entry 511 is win_done, whatever the code. It gives no font_vld or row_done, and fetching stops as in R6.
- R9: A write with cfg_we high loads cfg_bank into register cfg_sel at the clock edge. Responses in later cycles map codes through the new value, so the same page entry yields a different font address.
- R10: start, in any state, sets the pointer to 0 and enters the running state. No read is issued in a start cycle, and while idle next_chr has no effect.
- R11: While a read is outstanding (the cycle after ram_re), next_chr issues no read and the pointer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Bank register write enable |
| cfg_sel | input | 2 | Bank register index to write |
| cfg_bank | input | 3 | Bank number to write |
| start | input | 1 | Restart the window from entry 0 |
| next_chr | input | 1 | Request the next character |
| ram_re | output | 1 | Page RAM read enable |
| ram_addr | output | 9 | Page RAM read address |
| ram_rdata | input | 8 | Page RAM data, one cycle after ram_re |
| font_addr | output | 9 | Font ROM glyph address |
| font_vld | output | 1 | font_addr is valid this cycle |
| four_color | output | 1 | The addressed glyph is a four-color glyph |
| row_done | output | 1 | End-of-row mark seen |
| win_done | output | 1 | End-of-window mark or last entry seen |

## Verification
The assertions assume that the page RAM returns data exactly one cycle after ram_re and that reset is held for at least one clock edge. They also assume start is a plain strobe that may land in any cycle, including a response cycle. The bench models the RAM as a registered array keyed by the design's own ram_re and ram_addr, so the one-cycle latency always holds. Its random phase mixes start, next_chr and register writes at rates that cover restarts during outstanding reads and writes during responses.

// File: rtl/osd_cag_pkg.sv
package osd_cag_pkg;

    localparam int CODE_W_DEF  = 8;
    localparam int BANK_W_DEF  = 3;
    localparam int PAGE_AW_DEF = 9;

    typedef enum logic [1:0] {
        KIND_FONT    = 2'd0,
        KIND_ROW_END = 2'd1,
        KIND_WIN_END = 2'd2
    } code_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic code_kind_e classify_code(input logic [CODE_W_DEF-1:0] code);
        if (code == '0)
            return KIND_WIN_END;
        else if (code == CODE_W_DEF'(1))
            return KIND_ROW_END;
        else
            return KIND_FONT;
    endfunction

endpackage

// File: rtl/osd_bank_regs.sv
module osd_bank_regs #(
    parameter int BANK_W = osd_cag_pkg::BANK_W_DEF,
    parameter int NSEL   = 4,
    localparam int SEL_W = $clog2(NSEL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_o [NSEL]
);

    for (genvar i = 0; i < NSEL; i++) begin : g_reg
        logic [BANK_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= BANK_W'(i);
            else if (we && (sel == SEL_W'(i)))
                q <= wdata;
        end
        assign bank_o[i] = q;
    end

endmodule

// File: rtl/osd_code_decode.sv
module osd_code_decode
    import osd_cag_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int BANK_W = BANK_W_DEF,
    localparam int SEL_W   = 2,
    localparam int NSEL    = 1 << SEL_W,
    localparam int LOW_W   = CODE_W - SEL_W,
    localparam int FONT_AW = BANK_W + LOW_W
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [BANK_W-1:0]  banks [NSEL],
    output code_kind_e         kind,
    output logic [FONT_AW-1:0] addr,
    output logic               multi_color
);

    logic [SEL_W-1:0]  sel;
    logic [BANK_W-1:0] bank;

    always_comb begin
        sel         = code[CODE_W-1 -: SEL_W];
        bank        = banks[sel];
        addr        = {bank, code[LOW_W-1:0]};
        multi_color = &bank[1:0];
        kind        = classify_code(code);
    end

endmodule

// File: rtl/osd_fetch_seq.sv
module osd_fetch_seq
    import osd_cag_pkg::*;
#(
    parameter int PAGE_AW = PAGE_AW_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               next_chr,
    input  logic               resp_stop,
    output logic               ram_re,
    output logic [PAGE_AW-1:0] ram_addr,
    output logic               resp_vld,
    output logic               resp_last
);

    localparam logic [PAGE_AW-1:0] LAST_IDX = '1;

    seq_state_e         st_q;
    logic [PAGE_AW-1:0] ptr_q;
    logic               pend_q;
    logic               last_q;

    assign ram_re    = (st_q == SEQ_RUN) && next_chr && !pend_q && !start;
    assign ram_addr  = ptr_q;
    assign resp_vld  = pend_q;
    assign resp_last = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            ptr_q  <= '0;
            pend_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            pend_q <= ram_re;
            last_q <= ram_re && (ptr_q == LAST_IDX);
            if (start) begin
                st_q  <= SEQ_RUN;
                ptr_q <= '0;
            end else begin
                if (ram_re)
                    ptr_q <= ptr_q + 1'b1;
                if (pend_q && resp_stop)
                    st_q <= SEQ_IDLE;
            end
        end
    end

endmodule

// File: rtl/osd_char_addr_gen.sv
module osd_char_addr_gen
    import osd_cag_pkg::*;
#(
    parameter int CODE_W  = CODE_W_DEF,
    parameter int BANK_W  = BANK_W_DEF,
    parameter int PAGE_AW = PAGE_AW_DEF,
    localparam int SEL_W   = 2,
    localparam int NSEL    = 1 << SEL_W,
    localparam int FONT_AW = BANK_W + CODE_W - SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [BANK_W-1:0]  cfg_bank,
    input  logic               start,
    input  logic               next_chr,
    output logic               ram_re,
    output logic [PAGE_AW-1:0] ram_addr,
    input  logic [CODE_W-1:0]  ram_rdata,
    output logic [FONT_AW-1:0] font_addr,
    output logic               font_vld,
    output logic               four_color,
    output logic               row_done,
    output logic               win_done
);

    logic [BANK_W-1:0]  banks [NSEL];
    code_kind_e         kind;
    logic [FONT_AW-1:0] dec_addr;
    logic               dec_multi;
    logic               resp_vld;
    logic               resp_last;
    logic               resp_stop;

    osd_bank_regs #(.BANK_W(BANK_W), .NSEL(NSEL)) bank_i (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_bank),
        .bank_o (banks)
    );

    osd_code_decode #(.CODE_W(CODE_W), .BANK_W(BANK_W)) dec_i (
        .code        (ram_rdata),
        .banks       (banks),
        .kind        (kind),
        .addr        (dec_addr),
        .multi_color (dec_multi)
    );

    assign resp_stop = resp_last || (kind == KIND_WIN_END);

    osd_fetch_seq #(.PAGE_AW(PAGE_AW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .next_chr  (next_chr),
        .resp_stop (resp_stop),
        .ram_re    (ram_re),
        .ram_addr  (ram_addr),
        .resp_vld  (resp_vld),
        .resp_last (resp_last)
    );

    always_comb begin
        font_vld   = resp_vld && !resp_last && (kind == KIND_FONT);
        row_done   = resp_vld && !resp_last && (kind == KIND_ROW_END);
        win_done   = resp_vld && resp_stop;
        four_color = font_vld && dec_multi;
        font_addr  = font_vld ? dec_addr : '0;
    end

endmodule

// File: rtl/osd_char_addr_gen_chk.sv
module osd_char_addr_gen_chk #(
    parameter int CODE_W  = 8,
    parameter int BANK_W  = 3,
    parameter int PAGE_AW = 9,
    localparam int FONT_AW = BANK_W + CODE_W - 2
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [1:0]         cfg_sel,
    input logic [BANK_W-1:0]  cfg_bank,
    input logic               start,
    input logic               next_chr,
    input logic               ram_re,
    input logic [PAGE_AW-1:0] ram_addr,
    input logic [CODE_W-1:0]  ram_rdata,
    input logic [FONT_AW-1:0] font_addr,
    input logic               font_vld,
    input logic               four_color,
    input logic               row_done,
    input logic               win_done
);

    // R11: one read outstanding at most
    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        ram_re |=> !ram_re);

    // R3: a font address only answers a read of the previous cycle
    a_r3_vld_follows_read: assert property (@(posedge clk) disable iff (rst)
        font_vld |-> $past(ram_re));

    // R5: a row mark only answers a read of the previous cycle
    a_r5_row_follows_read: assert property (@(posedge clk) disable iff (rst)
        row_done |-> $past(ram_re));

    // R6: one event per response
    a_r6_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({font_vld, row_done, win_done}) <= 1);

    // R6: fetching halts after the window ends
    a_r6_halt_after_end: assert property (@(posedge clk) disable iff (rst)
        (win_done && !start) |=> !ram_re);

    // R4: four-color flag only with a valid font address
    a_r4_fc_with_vld: assert property (@(posedge clk) disable iff (rst)
        four_color |-> font_vld);

    // R10: no read in a start cycle
    a_r10_start_blocks_read: assert property (@(posedge clk) disable iff (rst)
        start |-> !ram_re);

endmodule

bind osd_char_addr_gen osd_char_addr_gen_chk #(
    .CODE_W(CODE_W), .BANK_W(BANK_W), .PAGE_AW(PAGE_AW)
) chk_i (.*);

// File: tb/osd_char_addr_gen_tb_top.sv
module osd_char_addr_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [2:0] cfg_bank;
    logic       start;
    logic       next_chr;
    logic       ram_re;
    logic [8:0] ram_addr;
    logic [7:0] ram_rdata = 8'h00;
    logic [8:0] font_addr;
    logic       font_vld;
    logic       four_color;
    logic       row_done;
    logic       win_done;

    always #5 clk = ~clk;

    osd_char_addr_gen dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_bank(cfg_bank),
        .start(start), .next_chr(next_chr), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .font_addr(font_addr), .font_vld(font_vld),
        .four_color(four_color), .row_done(row_done), .win_done(win_done)
    );

    logic [7:0] mem [512];
    always_ff @(posedge clk) if (ram_re) ram_rdata <= mem[ram_addr];

    int n_chk = 0;
    int n_bad = 0;

    // reference state derived from the requirements
    bit         m_run;
    logic [8:0] m_ptr;
    bit         m_pend;
    logic [8:0] m_paddr;
    logic [2:0] m_bank [4];
    bit         wrote;
    string      g_tag = "";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_font(logic [7:0] code);
        return {m_bank[code[7:6]], code[5:0]};
    endfunction

    task automatic cyc(bit nx, bit st, bit we, logic [1:0] sel, logic [2:0] wd);
        bit exp_re, e_vld, e_row, e_win, e_fc;
        logic [8:0] e_addr;
        logic [7:0] code;
        string ftag, rtag;
        @(negedge clk);
        next_chr = nx; start = st; cfg_we = we; cfg_sel = sel; cfg_bank = wd;
        #1;
        exp_re = m_run && nx && !m_pend && !st;
        rtag = !m_run ? "R10" : (m_pend ? "R11" : "R2");
        chk(rtag, "ram_re", 32'(ram_re), 32'(exp_re));
        if (exp_re) chk("R2", "ram_addr", 32'(ram_addr), 32'(m_ptr));
        e_vld = 0; e_row = 0; e_win = 0; e_fc = 0; e_addr = '0; code = 8'h00;
        if (m_pend) begin
            code = mem[m_paddr];
            if (m_paddr == 9'd511)   e_win = 1;
            else if (code == 8'h00)  e_win = 1;
            else if (code == 8'h01)  e_row = 1;
            else begin
                e_vld  = 1;
                e_addr = exp_font(code);
                e_fc   = (m_bank[code[7:6]][1:0] == 2'b11);
            end
        end
        if (g_tag != "")                                  ftag = g_tag;
        else if (code[7:6] != 2'b00 && code[5:1] == 5'd0) ftag = "R7";
        else if (!wrote)                                  ftag = "R1";
        else                                              ftag = "R3";
        chk(ftag, "font_vld", 32'(font_vld), 32'(e_vld));
        if (e_vld) chk(ftag, "font_addr", 32'(font_addr), 32'(e_addr));
        chk("R4", "four_color", 32'(four_color), 32'(e_fc));
        chk("R5", "row_done", 32'(row_done), 32'(e_row));
        chk((m_pend && m_paddr == 9'd511) ? "R8" : "R6", "win_done", 32'(win_done), 32'(e_win));
        @(posedge clk);
        if (e_win) m_run = 0;
        if (exp_re) begin
            m_paddr = m_ptr;
            m_ptr   = m_ptr + 1'b1;
        end
        m_pend = exp_re;
        if (st) begin
            m_run = 1;
            m_ptr = '0;
        end
        if (we) begin
            m_bank[sel] = wd;
            wrote = 1;
        end
    endtask

    task automatic run_all();
        void'($urandom(32'h5eed));
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_bank = 0; start = 0; next_chr = 0;
        for (int i = 0; i < 512; i++) mem[i] = 8'h02;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_run = 0; m_ptr = '0; m_pend = 0; m_paddr = '0; wrote = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 3'(i);
        #1;
        chk("R1", "font_vld", 32'(font_vld), 0);
        chk("R1", "row_done", 32'(row_done), 0);
        chk("R1", "win_done", 32'(win_done), 0);
        chk("R1", "ram_re", 32'(ram_re), 0);

        // reset bank values in use; idle strobes ignored
        mem[0] = 8'hC7; mem[1] = 8'h45; mem[2] = 8'h00;
        repeat (3) cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        repeat (8) cyc(1, 0, 0, 0, 0);

        // directed: worked example, row mark, aliasing codes, four-color, end
        mem[0] = 8'hAE; mem[1] = 8'h01; mem[2] = 8'h40; mem[3] = 8'h41;
        mem[4] = 8'hC5; mem[5] = 8'h80; mem[6] = 8'h81; mem[7] = 8'h00;
        cyc(0, 0, 1, 2'd2, 3'd5);
        cyc(0, 0, 1, 2'd1, 3'd0);
        cyc(0, 1, 0, 0, 0);
        repeat (20) cyc(1, 0, 0, 0, 0);

        // remap: same page, new bank value
        g_tag = "R9";
        cyc(0, 0, 1, 2'd2, 3'd7);
        cyc(0, 1, 0, 0, 0);
        repeat (6) cyc(1, 0, 0, 0, 0);
        g_tag = "";

        // full page without end mark: entry 511 ends the window
        for (int i = 0; i < 512; i++) mem[i] = 8'(1 + $urandom_range(254));
        cyc(0, 1, 0, 0, 0);
        repeat (1100) cyc(1, 0, 0, 0, 0);

        // constrained random
        for (int i = 0; i < 512; i++) begin
            int r = $urandom_range(99);
            mem[i] = (r < 3) ? 8'h00 : (r < 8) ? 8'h01 : 8'($urandom);
        end
        for (int k = 0; k < 25000; k++) begin
            cyc(($urandom_range(3) != 0), ($urandom_range(99) == 0),
                ($urandom_range(39) == 0), 2'($urandom), 3'($urandom));
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule